// File: doc/BRIEF.md
# Option-Byte Reset Sequencer

This block takes a chip out of reset. It reads an 8-bit nonvolatile option byte and uses it to set the reset-time settings. After a power-on reset it holds the system in reset through two supply checks. The first check is the power-on threshold and the second is the low-voltage detector's supply-good flag. The block then latches the option byte and waits for flash initialisation. After that wait it releases reset.

The length of the flash wait depends on two things: the fast-init option bit, and the core clock divider chosen by a 2-bit low-power-boot code. The block then drives a clock enable divided by that ratio. It gates NMI requests and external-pin reset requests by their option bits. It also drives low-power wakeup qualifiers for the same two pins.

Three events in the run state restart the sequence from option loading and skip the supply checks: a system-reset request, a low-power recovery request, or an enabled external reset. The reset-pin enable is re-captured only after a power-on reset.

Top module: `opt_reset_seq`

## Requirements
- R1: After a power-on reset, `hold_rst_o` stays 1 while `vth_ok_i` is 0. It then stays 1 while `lvd_ok_i` is 0. Option loading starts only after both flags have been seen high.
- R2: The low-power-boot code is {option bit 4, option bit 0}. It sets `clkdiv_o` to 7, 3, 1 or 0 for codes 00, 01, 10 and 11.
- R3: With option bit 5 (fast-init) at 0, the flash wait lasts 16 × (`clkdiv_o` + 1) cycles. Reset is released `W` + 2 rising edges after the edge that starts the sequence, where `W` is the wait length. That starting edge is either the edge that samples `lvd_ok_i` high or the edge that samples the restart event.
- R4: With fast-init at 1, the flash wait lasts 16 cycles whatever the divider is.
- R5: `div_en_o` is 0 whenever reset is held. In run cycle k, with k = 0 for the first cycle after release, `div_en_o` is 1 exactly when k mod (`clkdiv_o` + 1) equals `clkdiv_o`.
- R6: Option bit 3 is the reset-pin enable. When the captured value is 0, a low `rst_pin_i` gives no `ext_rst_req_o`, no `wake_rst_o` and no reset.
- R7: Option bit 2 is the NMI enable. When it is 0, `nmi_req_o` and `wake_nmi_o` stay 0. When it is 1, a low `nmi_pin_i` in run asserts both outputs.
- R8: The reset-pin enable is captured only on the option load that follows a power-on reset. A system-reset or recovery load keeps the previous value.
- R9: In run, `sys_rst_req_i` or `wake_req_i` reasserts `hold_rst_o` on the next edge and reloads the options, even with `lvd_ok_i` at 0.
- R10: `por_i` high forces power-on hold from any state. `hold_rst_o` is 1 after the next edge.
- R11: With the reset pin enabled, a low `rst_pin_i` in run raises `ext_rst_req_o` at once. On the next edge the sequence restarts from option loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset indication |
| vth_ok_i | input | 1 | Supply above the power-on threshold |
| lvd_ok_i | input | 1 | Supply-good from the low-voltage detector |
| sys_rst_req_i | input | 1 | System reset request |
| wake_req_i | input | 1 | Low-power recovery request |
| rst_pin_i | input | 1 | Raw external reset pin level (low = asserted) |
| nmi_pin_i | input | 1 | Raw NMI pin level (low = asserted) |
| opt_byte_i | input | 8 | Nonvolatile option byte |
| clkdiv_o | output | 3 | Reset value of the core/system divider field |
| div_en_o | output | 1 | Divided clock enable |
| hold_rst_o | output | 1 | System held in reset |
| nmi_req_o | output | 1 | Gated NMI request |
| ext_rst_req_o | output | 1 | Gated external reset request |
| wake_rst_o | output | 1 | Reset pin qualified as a wakeup source |
| wake_nmi_o | output | 1 | NMI pin qualified as a wakeup source |

## Verification
Some properties are checked on every cycle. The supply waits hold their state while the flags are low, and a POR always lands in the hold state. The flash counter counts down by one each cycle. The divided enable never fires during hold and never fires twice in a row unless the divide is 1. A run-state restart always goes to option loading, and a disabled reset pin never takes the block out of run. The pin enable keeps its value on loads that do not follow a POR.

Other behaviour can only be shown by the bench's scenarios. These are:
- the exact release cycle for every divider code with and without fast-init;
- the code-to-divider mapping;
- the pulse pattern of the divided enable;
- the pin and NMI gating as option values change across POR and system resets.

// File: rtl/opt_rst_pkg.sv
package opt_rst_pkg;
  localparam int DIV_W     = 3;
  localparam int OPT_FAST  = 5;
  localparam int OPT_LP_HI = 4;
  localparam int OPT_PIN   = 3;
  localparam int OPT_NMI   = 2;
  localparam int OPT_LP_LO = 0;

  typedef enum logic [2:0] {
    ST_POR_HOLD,
    ST_LVD_WAIT,
    ST_LOAD,
    ST_FLASH,
    ST_RUN
  } seq_state_e;

  function automatic logic [DIV_W-1:0] lp_to_div(input logic [1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      2'b00:   d = 3'd7;
      2'b01:   d = 3'd3;
      2'b10:   d = 3'd1;
      default: d = 3'd0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/opt_seq_fsm.sv
module opt_seq_fsm
  import opt_rst_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             vth_ok_i,
  input  logic             lvd_ok_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] init_len_i,
  output seq_state_e       state_o,
  output logic             load_o,
  output logic             por_load_o,
  output logic             hold_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             from_por_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR_HOLD: if (vth_ok_i) state_d = ST_LVD_WAIT;
      ST_LVD_WAIT: if (lvd_ok_i) state_d = ST_LOAD;
      ST_LOAD:     state_d = ST_FLASH;
      ST_FLASH:    if (cnt_q == '0) state_d = ST_RUN;
      ST_RUN:      if (restart_i) state_d = ST_LOAD;
      default:     state_d = ST_POR_HOLD;
    endcase
    if (por_i) state_d = ST_POR_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_POR_HOLD;
      cnt_q      <= '0;
      from_por_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD) cnt_q <= init_len_i;
      else if (state_q == ST_FLASH && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (por_i || state_q == ST_POR_HOLD) from_por_q <= 1'b1;
      else if (state_q == ST_LOAD) from_por_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign load_o     = (state_q == ST_LOAD);
  assign por_load_o = load_o && from_por_q;
  assign hold_o     = (state_q != ST_RUN);

  AST_POR_HOLD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POR_HOLD && !vth_ok_i) |=> state_q == ST_POR_HOLD); // R1
  AST_LVD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LVD_WAIT && !lvd_ok_i && !por_i) |=> state_q == ST_LVD_WAIT); // R1
  AST_INIT_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLASH && cnt_q != '0 && !por_i)
      |=> (state_q == ST_FLASH && cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
  AST_POR_FORCES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (state_q == ST_POR_HOLD && hold_o)); // R10
endmodule

// File: rtl/opt_cfg_regs.sv
module opt_cfg_regs
  import opt_rst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             por_load_i,
  input  logic [7:0]       opt_i,
  output logic [DIV_W-1:0] div_o,
  output logic             pin_en_o,
  output logic             nmi_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o    <= lp_to_div(2'b00);
      pin_en_o <= 1'b0;
      nmi_en_o <= 1'b0;
    end else if (load_i) begin
      div_o    <= lp_to_div({opt_i[OPT_LP_HI], opt_i[OPT_LP_LO]});
      nmi_en_o <= opt_i[OPT_NMI];
      if (por_load_i) pin_en_o <= opt_i[OPT_PIN];
    end
  end

  AST_PIN_CFG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !por_load_i) |=> $stable(pin_en_o)); // R8
endmodule

// File: rtl/opt_clk_div.sv
module opt_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             en_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (hold_i)         cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = !hold_i && (cnt_q == div_i);

  AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && div_i != '0 && $stable(div_i)) |=> !en_o); // R5
endmodule

// File: rtl/opt_reset_seq.sv
module opt_reset_seq
  import opt_rst_pkg::*;
#(
  parameter int INIT_BASE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             vth_ok_i,
  input  logic             lvd_ok_i,
  input  logic             sys_rst_req_i,
  input  logic             wake_req_i,
  input  logic             rst_pin_i,
  input  logic             nmi_pin_i,
  input  logic [7:0]       opt_byte_i,
  output logic [DIV_W-1:0] clkdiv_o,
  output logic             div_en_o,
  output logic             hold_rst_o,
  output logic             nmi_req_o,
  output logic             ext_rst_req_o,
  output logic             wake_rst_o,
  output logic             wake_nmi_o
);
  localparam int MAX_WAIT = INIT_BASE * (2 ** DIV_W);
  localparam int CNT_W    = $clog2(MAX_WAIT);

  seq_state_e       state;
  logic             load, por_load, run, restart;
  logic             pin_en, nmi_en;
  logic [DIV_W-1:0] div_new;
  logic [CNT_W-1:0] init_len;
  int               wait_cyc;

  // Wait length is computed from the byte being latched, not from the old divider.
  always_comb begin
    div_new  = lp_to_div({opt_byte_i[OPT_LP_HI], opt_byte_i[OPT_LP_LO]});
    wait_cyc = opt_byte_i[OPT_FAST] ? INIT_BASE : INIT_BASE * (int'(div_new) + 1);
    init_len = CNT_W'(wait_cyc - 1);
  end

  assign run           = (state == ST_RUN);
  assign wake_rst_o    = pin_en && !rst_pin_i;
  assign wake_nmi_o    = nmi_en && !nmi_pin_i;
  assign ext_rst_req_o = run && wake_rst_o;
  assign nmi_req_o     = run && wake_nmi_o;
  assign restart       = sys_rst_req_i || wake_req_i || ext_rst_req_o;

  opt_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .vth_ok_i   (vth_ok_i),
    .lvd_ok_i   (lvd_ok_i),
    .restart_i  (restart),
    .init_len_i (init_len),
    .state_o    (state),
    .load_o     (load),
    .por_load_o (por_load),
    .hold_o     (hold_rst_o)
  );

  opt_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .por_load_i (por_load),
    .opt_i      (opt_byte_i),
    .div_o      (clkdiv_o),
    .pin_en_o   (pin_en),
    .nmi_en_o   (nmi_en)
  );

  opt_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_rst_o),
    .div_i  (clkdiv_o),
    .en_o   (div_en_o)
  );

  AST_RESTART_SKIPS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (sys_rst_req_i || wake_req_i) && !por_i) |=> (state == ST_LOAD && hold_rst_o)); // R9
  AST_PIN_DISABLED_NO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !pin_en && !sys_rst_req_i && !wake_req_i && !por_i) |=> run); // R6
  AST_NMI_ONLY_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> (!hold_rst_o && nmi_en)); // R7
  AST_EXT_RST_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_req_o && !por_i) |=> state == ST_LOAD); // R11
endmodule

// File: tb/opt_reset_seq_test.sv
`timescale 1ns/1ps
module opt_reset_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0, vth = 1'b0, lvd = 1'b0, sys = 1'b0, wake = 1'b0;
  logic       rpin = 1'b1, npin = 1'b1;
  logic [7:0] opt = 8'h00;
  logic [2:0] clkdiv;
  logic       div_en, hold, nmi_req, ext_req, wk_rst, wk_nmi;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  opt_reset_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .vth_ok_i(vth), .lvd_ok_i(lvd),
    .sys_rst_req_i(sys), .wake_req_i(wake), .rst_pin_i(rpin), .nmi_pin_i(npin),
    .opt_byte_i(opt), .clkdiv_o(clkdiv), .div_en_o(div_en), .hold_rst_o(hold),
    .nmi_req_o(nmi_req), .ext_rst_req_o(ext_req), .wake_rst_o(wk_rst), .wake_nmi_o(wk_nmi)
  );

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic int exp_div(input logic [7:0] ob);
    int c = {ob[4], ob[0]};
    return (1 << (3 - c)) - 1;
  endfunction

  function automatic int exp_wait(input logic [7:0] ob);
    return ob[5] ? 16 : 16 * (exp_div(ob) + 1);
  endfunction

  function automatic logic [7:0] mk_opt(input int fast, input int code, input int pin,
                                        input int nmi);
    logic [7:0] o;
    o    = '0;
    o[5] = fast[0]; o[4] = code[1]; o[3] = pin[0]; o[2] = nmi[0]; o[0] = code[0];
    o[7] = fast[0]; o[6] = ~fast[0]; o[1] = code[0];  // reserved bits toggled
    return o;
  endfunction

  task automatic wait_release(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (hold && n < 1000);
  endtask

  task automatic do_por(input logic [7:0] ob, output int n);
    @(negedge clk); por = 1; vth = 0; lvd = 0; sys = 0; wake = 0; opt = ob;
    @(negedge clk); chk("R10 hold after por", hold, 1);
    @(negedge clk); por = 0;
    repeat (3) @(negedge clk);
    chk("R1 hold while below threshold", hold, 1);
    vth = 1;
    repeat (3) @(negedge clk);
    chk("R1 hold while supply not good", hold, 1);
    lvd = 1;
    wait_release(n);
  endtask

  task automatic do_restart(input logic [7:0] ob, input bit use_wake, output int n);
    @(negedge clk); opt = ob; lvd = 0;
    if (use_wake) wake = 1; else sys = 1;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      if (n == 1) begin
        sys = 0; wake = 0;
        chk("R9 hold after restart request", hold, 1);
      end
    end while (hold && n < 1000);
  endtask

  task automatic check_div(input int d);
    for (int k = 0; k < 20; k++) begin
      chk($sformatf("R5 div_en d=%0d k=%0d", d, k), div_en, ((k % (d + 1)) == d) ? 1 : 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic pin_low(input int exp_req, output bit restarted);
    int n;
    @(negedge clk); rpin = 0; #1;
    chk("R6/R11 ext_rst_req", ext_req, exp_req);
    chk("R6/R11 wake_rst", wk_rst, exp_req);
    repeat (3) @(posedge clk);
    #1;
    restarted = hold;
    @(negedge clk); rpin = 1;
    if (hold) wait_release(n);
  endtask

  task automatic nmi_low(input int exp);
    @(negedge clk); npin = 0; #1;
    chk("R7 nmi_req", nmi_req, exp);
    chk("R7 wake_nmi", wk_nmi, exp);
    @(negedge clk); npin = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int  n;
    bit  rs;
    logic [7:0] ob;
    repeat (3) @(negedge clk);
    chk("R1 reset hold", hold, 1);
    chk("R2 reset divider", clkdiv, 7);
    chk("R5 reset div_en", div_en, 0);
    chk("R6 reset ext_rst_req", ext_req, 0);
    chk("R7 reset nmi_req", nmi_req, 0);
    rst_n = 1;

    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 4; c++) begin
        ob = mk_opt(f, c, 0, 0);
        do_por(ob, n);
        chk($sformatf("R3/R4 por release f=%0d c=%0d", f, c), n, exp_wait(ob) + 2);
        chk($sformatf("R2 divider c=%0d", c), clkdiv, exp_div(ob));
        check_div(exp_div(ob));
        ob = mk_opt(f, 3 - c, 0, 0);
        do_restart(ob, c[0], n);
        chk($sformatf("R3/R9 restart release f=%0d c=%0d", f, 3 - c), n, exp_wait(ob) + 2);
        chk($sformatf("R2 reloaded divider c=%0d", 3 - c), clkdiv, exp_div(ob));
        check_div(exp_div(ob));
      end
    end

    do_por(mk_opt(1, 3, 1, 1), n);
    chk("R4 fast release", n, 18);
    pin_low(1, rs);
    chk("R11 enabled pin restarts", rs, 1);
    nmi_low(1);
    do_restart(mk_opt(1, 3, 0, 0), 1'b0, n);
    pin_low(1, rs);
    chk("R8 pin enable kept through system reset", rs, 1);
    nmi_low(0);
    do_por(mk_opt(1, 3, 0, 1), n);
    pin_low(0, rs);
    chk("R6 disabled pin no reset", rs, 0);
    do_restart(mk_opt(1, 3, 1, 1), 1'b1, n);
    pin_low(0, rs);
    chk("R8 pin disable kept through recovery", rs, 0);
    nmi_low(1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule